// File: doc/BRIEF.md
# Gated Rate Meter with Automatic Gate Selection

This block measures how often a digital pulse signal rises. The signal arrives already conditioned but asynchronous to the system clock. It is resynchronised and reduced to one-cycle rising-edge events. Those events are summed over a gate window. The window is timed by a strobe, `ref_tick`, which comes from a fixed reference timebase and is already in the system clock domain. When a window closes, its sum is scaled to hertz and latched into `result`, together with a one-cycle `result_valid` strobe. The sum then restarts from zero without losing an edge.

There are two gate lengths: a long one (nominally 1 s) and a short one (nominally 0.1 s). The block picks between them from its own previous result, with hysteresis. A result from the short gate is multiplied by ten. An optional divide-by-ten prescaler, enabled by `prescale_en`, stretches the usable input range, and its results are also multiplied by ten. `result_short` reports which gate produced the result on show. The input rate must stay below half the system clock.

`rst_n` is asserted asynchronously and must be released synchronously to `clk`.

Top module: `rate_meter`

## Requirements
- R1: While `rst_n` is low, `result` is 0, `result_valid` is 0 and `result_short` is 0, and the long gate is selected.
- R2: With the prescaler off and the long gate in use, `result` equals the number of low-to-high transitions of `sig_in` seen in the window. Falling edges and steady levels add nothing.
- R3: A window lasts `LONG_TICKS` `ref_tick` strobes on the long gate and `SHORT_TICKS` strobes on the short gate. No window can close in a cycle without `ref_tick`.
- R4: At the close of each window, `result_valid` is high for exactly one cycle. The next window starts from zero, and every edge falls into exactly one window.
- R5: A result from the short gate is the edge count multiplied by 10.
- R6: With `prescale_en` high, one count is taken per ten rising edges and the result is multiplied by a further 10. The leftover edges carry into the next window while the prescaler stays enabled. Dropping `prescale_en` discards them.
- R7: The gate switches to short when a result is strictly above `UP_TH`. It switches to long when a result is strictly below `DOWN_TH`. Otherwise it keeps its setting. A change takes effect from the next window onward.
- R8: `result_short` is 1 when the result on show came from the short gate, and 0 when it came from the long gate.
- R9: `result` and `result_short` change only in the cycle where `result_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| sig_in | input | 1 | Conditioned pulse input, asynchronous to clk |
| ref_tick | input | 1 | One-cycle strobe from the reference timebase |
| prescale_en | input | 1 | Enables the divide-by-ten input path |
| result | output | 32 | Last measured rate in hertz |
| result_valid | output | 1 | One-cycle strobe when `result` is updated |
| result_short | output | 1 | Gate that produced `result` (1 = short) |

## Verification
Fixed bursts are counted on both gates. Rates placed exactly at, and one step past, each hysteresis threshold show whether the comparisons are strict and whether the gate setting holds inside the band. One directed window ends with the input held high and the next window only brings it low, which separates rising-edge counting from level or falling-edge counting. Prescaled sequences whose edge totals are not multiples of ten show whether the remainder carries over and whether disabling the prescaler clears it. Random burst lengths, pulse widths and prescaler settings then exercise gate switching in both directions, and a stretch without `ref_tick` shows that the gate depends on the reference strobe and not on the system clock.

// File: rtl/rate_meter_pkg.sv
package rate_meter_pkg;

  localparam int CNT_W = 32;

  typedef enum logic {
    GATE_LONG  = 1'b0,
    GATE_SHORT = 1'b1
  } gate_range_e;

  // x * 10 by shift-add, truncated to the count width
  function automatic logic [CNT_W-1:0] times_ten(input logic [CNT_W-1:0] x);
    return (x << 3) + (x << 1);
  endfunction

endpackage

// File: rtl/rm_edge_sync.sv
module rm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/rm_prescaler.sv
module rm_prescaler #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic edge_in,
  output logic pulse
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    pulse = en && edge_in && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (!en)          cnt_d = '0;
    else if (pulse)   cnt_d = '0;
    else if (edge_in) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rm_gate_timer.sv
module rm_gate_timer #(
  parameter int unsigned LONG_TICKS  = 10_000_000,
  parameter int unsigned SHORT_TICKS = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic short_sel,
  output logic gate_end
);
  localparam int TW = $clog2(LONG_TICKS + 1);
  localparam logic [TW-1:0] LONG_LAST  = TW'(LONG_TICKS - 1);
  localparam logic [TW-1:0] SHORT_LAST = TW'(SHORT_TICKS - 1);

  logic [TW-1:0] tick_q;
  logic [TW-1:0] tick_d;
  logic [TW-1:0] last;

  always_comb begin
    last     = short_sel ? SHORT_LAST : LONG_LAST;
    gate_end = ref_tick && (tick_q >= last);
    tick_d   = tick_q;
    if (gate_end)      tick_d = '0;
    else if (ref_tick) tick_d = tick_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_d;
  end

endmodule

// File: rtl/rate_meter.sv
module rate_meter
  import rate_meter_pkg::*;
#(
  parameter int unsigned LONG_TICKS  = 10_000_000,
  parameter int unsigned SHORT_TICKS = 1_000_000,
  parameter int unsigned UP_TH       = 1_000_000,
  parameter int unsigned DOWN_TH     = 900_000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic             ref_tick,
  input  logic             prescale_en,
  output logic [CNT_W-1:0] result,
  output logic             result_valid,
  output logic             result_short
);
  localparam int PRE_DIV = 10;

  logic rise;
  logic pre_pulse;
  logic edge_cnt;
  logic gate_end;

  gate_range_e      range_q, range_d;
  gate_range_e      used_q,  used_d;
  logic [CNT_W-1:0] acc_q,   acc_d;
  logic [CNT_W-1:0] res_q,   res_d;
  logic             vld_q,   vld_d;
  logic [CNT_W-1:0] closing;
  logic [CNT_W-1:0] scaled;

  rm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sig_in), .rise(rise)
  );

  rm_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(prescale_en), .edge_in(rise), .pulse(pre_pulse)
  );

  rm_gate_timer #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_gate (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .short_sel(range_q == GATE_SHORT), .gate_end(gate_end)
  );

  always_comb begin
    edge_cnt = prescale_en ? pre_pulse : rise;
    // an edge in the closing cycle belongs to the window that closes
    closing  = acc_q + CNT_W'(edge_cnt);
    scaled   = closing;
    if (range_q == GATE_SHORT) scaled = times_ten(scaled);
    if (prescale_en)           scaled = times_ten(scaled);

    acc_d   = closing;
    res_d   = res_q;
    used_d  = used_q;
    range_d = range_q;
    vld_d   = 1'b0;
    if (gate_end) begin
      acc_d  = '0;
      res_d  = scaled;
      used_d = range_q;
      vld_d  = 1'b1;
      if (scaled > UP_TH)        range_d = GATE_SHORT;
      else if (scaled < DOWN_TH) range_d = GATE_LONG;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      res_q   <= '0;
      vld_q   <= 1'b0;
      used_q  <= GATE_LONG;
      range_q <= GATE_LONG;
    end else begin
      acc_q   <= acc_d;
      res_q   <= res_d;
      vld_q   <= vld_d;
      used_q  <= used_d;
      range_q <= range_d;
    end
  end

  assign result       = res_q;
  assign result_valid = vld_q;
  assign result_short = (used_q == GATE_SHORT);

endmodule

// File: rtl/rate_meter_chk.sv
module rate_meter_chk #(
  parameter int unsigned UP_TH   = 1_000_000,
  parameter int unsigned DOWN_TH = 900_000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ref_tick,
  input logic [31:0] result,
  input logic        result_valid,
  input logic        result_short,
  input logic        range_short
);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result));

  a_r9_hold_range_tag: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result_short));

  a_r7_switch_up: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && (result > UP_TH)) |-> range_short);

  a_r7_switch_down: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && (result < DOWN_TH)) |-> !range_short);

  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(range_short));

  a_r3_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> !result_valid);

endmodule

bind rate_meter rate_meter_chk #(.UP_TH(UP_TH), .DOWN_TH(DOWN_TH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .result(result),
  .result_valid(result_valid), .result_short(result_short),
  .range_short(range_q == rate_meter_pkg::GATE_SHORT)
);

// File: tb/rate_meter_test.sv
module rate_meter_test;
  localparam int unsigned LT = 400;
  localparam int unsigned ST = 40;
  localparam int unsigned UP = 60;
  localparam int unsigned DN = 30;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sig_in;
  logic        ref_tick;
  logic        prescale_en;
  logic [31:0] result;
  logic        result_valid;
  logic        result_short;

  int  checks = 0;
  int  errors = 0;
  bit  exp_short = 1'b0;
  int  phase = 0;
  longint last_result = 0;
  time t_last = 0;

  always #10 clk = ~clk;

  rate_meter #(.LONG_TICKS(LT), .SHORT_TICKS(ST), .UP_TH(UP), .DOWN_TH(DN)) uut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .ref_tick(ref_tick),
    .prescale_en(prescale_en), .result(result), .result_valid(result_valid),
    .result_short(result_short)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected rate for a window; updates the prescaler remainder
  function automatic longint model(input int edges, input bit pre, input bit shrt);
    longint c;
    if (pre) begin
      c = (phase + edges) / 10;
      phase = (phase + edges) % 10;
      c = c * 10;
    end else begin
      c = edges;
    end
    if (shrt) c = c * 10;
    return c & 64'hFFFF_FFFF;
  endfunction

  task automatic wait_valid(output time t);
    bit found = 1'b0;
    t = $time;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (result_valid) begin
        found = 1'b1;
        t = $time;
        break;
      end
    end
    chk(found, "R3 window close timeout", 0, 1);
  endtask

  task automatic run_window(input int n, input bit pre, input bit extra, input bit chk_period);
    longint expv;
    time    t_now;
    string  tag;
    if (sig_in) begin
      sig_in = 1'b0;
      repeat (2) @(negedge clk);
    end
    prescale_en = pre;
    if (!pre) phase = 0;
    for (int i = 0; i < n; i++) begin
      sig_in = 1'b1;
      repeat ($urandom_range(1, 2)) @(negedge clk);
      sig_in = 1'b0;
      repeat ($urandom_range(1, 2)) @(negedge clk);
    end
    if (extra) begin
      sig_in = 1'b1;
      @(negedge clk);
    end
    chk(result == last_result, "R9 result held inside window", result, last_result);
    wait_valid(t_now);
    expv = model(n + int'(extra), pre, exp_short);
    tag  = pre ? "R6 prescaled rate" : (exp_short ? "R5 short-gate rate" : "R2 edge count");
    chk(result == expv, tag, result, expv);
    chk(result_short == exp_short, "R7,R8 gate used", result_short, exp_short);
    if (chk_period)
      chk((t_now - t_last) / 20 == (exp_short ? ST : LT), "R3 window length",
          (t_now - t_last) / 20, exp_short ? ST : LT);
    t_last = t_now;
    last_result = result;
    // R7 hysteresis model
    if (expv > UP)      exp_short = 1'b1;
    else if (expv < DN) exp_short = 1'b0;
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    time t0;
    bit  seen;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sig_in = 1'b0; ref_tick = 1'b1; prescale_en = 1'b0;
    repeat (5) @(negedge clk);
    chk(result == 0, "R1 result at reset", result, 0);
    chk(result_valid == 0, "R1 valid at reset", result_valid, 0);
    chk(result_short == 0, "R1 long gate at reset", result_short, 0);
    rst_n = 1'b1;

    wait_valid(t_last);
    chk(result == 0, "R2 no edges gives zero", result, 0);

    run_window(25, 0, 0, 0);
    run_window(60, 0, 0, 1);   // R7 exactly at upper threshold: stays long
    run_window(61, 0, 0, 1);   // R7 one above: go short
    run_window(6, 0, 0, 1);    // R5 60 on short gate, in band
    run_window(3, 0, 0, 1);    // R7 exactly at lower threshold: stays short
    run_window(2, 0, 0, 1);    // R7 below: back to long
    run_window(10, 0, 1, 1);   // ends held high: 11 rises
    run_window(0, 0, 0, 1);    // R2 only a falling edge: zero

    run_window(25, 1, 0, 1);   // R6 remainder 5
    run_window(15, 1, 0, 1);   // R6 remainder carried
    run_window(9, 1, 0, 1);
    run_window(5, 0, 0, 1);    // R6 disabling clears remainder
    run_window(1, 1, 0, 1);

    // R3 gate frozen without ref_tick
    ref_tick = 1'b0;
    for (int i = 0; i < 10; i++) begin
      sig_in = 1'b1; @(negedge clk);
      sig_in = 1'b0; @(negedge clk);
    end
    seen = 1'b0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (result_valid) seen = 1'b1;
    end
    chk(!seen, "R3 no window close without ref_tick", seen, 0);
    ref_tick = 1'b1;
    wait_valid(t0);
    chk(result == 10, "R3,R4 paused window keeps its edges", result, 10);
    chk(!result_short, "R8 gate used", result_short, 0);
    t_last = t0; last_result = result;
    @(negedge clk);
    chk(!result_valid, "R4 valid lasts one cycle", result_valid, 0);
    t_last = t_last;

    for (int w = 0; w < 30; w++) begin
      int n;
      bit pre;
      n   = exp_short ? int'($urandom_range(0, 7)) : int'($urandom_range(0, 90));
      pre = bit'($urandom_range(0, 1));
      run_window(n, pre, 0, w != 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule